// File: doc/BRIEF.md
# Prefetch Admission and Miss Tracker

This block sits beside a second-level cache. It decides whether each prefetch request may enter the level's read queue, and it hands out the small pool of registers that track misses outstanding to the next level. A prefetch request carries the line address to fetch, the address of the demand read that triggered it, and a fill target: this level or only the level below. Each request is answered one cycle later with an accept or a reject pulse. A rejection comes with a two-bit reason.

The read queue is a single FIFO. Demand reads from the level above and accepted prefetches share it, with no priority between them. It is drained by at most one request per cycle at its head. Independently, demand misses at this level ask for a tracking register. A grant or a stall is returned in the same cycle. A register that is released in a cycle can be granted again in that same cycle. The queue occupancy and the tracker occupancy are driven as outputs.

Top module: `pf_admit_tracker`

## Requirements
- R1: After reset the read queue is empty (`rd_valid`=0, `rq_count`=0), every tracking register is free (`trk_count`=0), and neither `pf_ack` nor `pf_nak` is high.
- R2: A prefetch whose address bits [31:12] differ from those of its trigger address is rejected. In the following cycle `pf_nak` is high and `pf_why`=1 (page cross). The read queue and the trackers are unchanged. This check has the highest priority among the reasons.
- R3: A prefetch on the same page is rejected with `pf_why`=2 (queue full) when the queue count, plus one if a demand read is written in the same cycle, already equals 32.
- R4: A prefetch that targets this level (`pf_to_l2`=1) needs a tracking register. If none is left after the demand miss of that cycle, it is rejected with `pf_why`=3. A prefetch that targets only the lower level (`pf_to_l2`=0) never takes a register and is never rejected for this reason.
- R5: An accepted prefetch raises `pf_ack` for exactly one cycle, the cycle after the request. It is appended to the queue tail. For a this-level target, `pf_trk` carries the register it took. `pf_ack` and `pf_nak` are never high together.
- R6: The queue is strict FIFO and pops at most one entry per cycle while `rd_ready` is high. Its head shows the address, the prefetch flag, the fill target and the tracker number (0 for demand reads and lower-level prefetches). When a demand read and a prefetch are written in the same cycle, the demand read goes first.
- R7: A demand miss (`mq_valid`) is granted in the same cycle the lowest-numbered free tracking register (`mq_gnt`, `mq_trk`). When no register is free, `mq_stall` is high instead.
- R8: A register released through `rel_valid`/`rel_trk` counts as free in the release cycle and may be granted in that cycle. Releasing a register that is already free has no effect on `trk_count`.
- R9: `rq_count` equals the number of queued entries and `trk_count` the number of busy registers.
- R10: When a demand miss and a this-level prefetch compete for trackers in one cycle, the demand miss is served first. The prefetch gets the next free register, or is rejected with reason 3.
- R11: `dq_ready` is low exactly when the queue holds 32 entries. A demand read offered then is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dq_valid | input | 1 | Demand read offered to the read queue |
| dq_addr | input | 32 | Demand read address |
| dq_ready | output | 1 | Queue can take a demand read |
| pf_valid | input | 1 | Prefetch request |
| pf_addr | input | 32 | Prefetch line address |
| pf_trig | input | 32 | Address of the triggering demand read |
| pf_to_l2 | input | 1 | 1: fill into this level, 0: lower level only |
| pf_ack | output | 1 | Prefetch accepted (one-cycle pulse) |
| pf_nak | output | 1 | Prefetch rejected (one-cycle pulse) |
| pf_why | output | 2 | Reject reason: 1 page, 2 full, 3 no tracker |
| pf_trk | output | 4 | Tracker taken by an accepted this-level prefetch |
| rd_valid | output | 1 | Queue head is valid |
| rd_ready | input | 1 | Consumer takes the head this cycle |
| rd_addr | output | 32 | Head address |
| rd_is_pf | output | 1 | Head is a prefetch |
| rd_to_l2 | output | 1 | Head fill target |
| rd_trk | output | 4 | Head tracker number |
| mq_valid | input | 1 | Demand miss asks for a tracker |
| mq_gnt | output | 1 | Tracker granted |
| mq_stall | output | 1 | Miss stalled, no tracker free |
| mq_trk | output | 4 | Granted tracker number |
| rel_valid | input | 1 | Release a tracker |
| rel_trk | input | 4 | Tracker to release |
| rq_count | output | 6 | Queue occupancy |
| trk_count | output | 5 | Busy tracker count |

## Verification
Directed patterns come first. A same-page prefetch next to a page-crossing one separates the address compare from the other reasons. Filling the queue to 31, then offering a demand read and a prefetch together, shows that the demand read is counted before the room check. Exhausting the trackers and then sending a this-level prefetch and a lower-level prefetch separates the two fill targets. Release-and-reallocate in one cycle, a duplicate release, and one free register contested by a demand miss and a prefetch each expose a different ordering choice. A long mixed phase with random readiness, page crossings and releases then follows a behavioural model cycle by cycle.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

    // Reject reasons reported with a prefetch response
    typedef enum logic [1:0] {
        WHY_NONE = 2'd0,
        WHY_PAGE = 2'd1,
        WHY_FULL = 2'd2,
        WHY_TRK  = 2'd3
    } why_e;

    typedef struct packed {
        logic ok;
        why_e why;
    } verdict_t;

    localparam int DEF_ADDR_W   = 32;
    localparam int DEF_PAGE_LSB = 12;
    localparam int DEF_RQ_DEPTH = 32;
    localparam int DEF_TRK_NUM  = 16;

endpackage

// File: rtl/pfq_fifo.sv
module pfq_fifo #(
    parameter int W     = 38,
    parameter int DEPTH = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push_a,
    input  logic [W-1:0]               din_a,
    input  logic                       push_b,
    input  logic [W-1:0]               din_b,
    input  logic                       pop,
    output logic [W-1:0]               head,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rp, wp, wp_b;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign wp_b = push_a ? bump(wp) : wp;
    assign head = mem[rp];

    always_ff @(posedge clk) begin
        if (push_a) mem[wp]   <= din_a;
        if (push_b) mem[wp_b] <= din_b;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rp    <= '0;
            wp    <= '0;
            count <= '0;
        end else begin
            wp <= push_b ? bump(wp_b) : wp_b;
            if (pop) rp <= bump(rp);
            count <= count + CW'(push_a) + CW'(push_b) - CW'(pop);
        end
    end

    a_r6_count_bound: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (push_a && push_b) |-> (count < CW'(DEPTH - 1)));

    a_r6_no_underflow: assert property (@(posedge clk) disable iff (rst)
        pop |-> (count != '0));

endmodule

// File: rtl/pfq_pool.sv
module pfq_pool #(
    parameter int N = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     rel_v,
    input  logic [$clog2(N)-1:0]     rel_id,
    input  logic                     dm_req,
    input  logic                     pf_take,
    output logic                     dm_gnt,
    output logic [$clog2(N)-1:0]     dm_id,
    output logic                     pf_avail,
    output logic [$clog2(N)-1:0]     pf_id,
    output logic [$clog2(N+1)-1:0]   busy_cnt
);
    localparam int IW = $clog2(N);
    localparam int CW = $clog2(N + 1);

    logic [N-1:0] busy, avail, after_dm;
    logic         dm_hit;

    // A register being released this cycle is already free for reuse
    always_comb begin
        avail = ~busy;
        if (rel_v) avail[rel_id] = 1'b1;
    end

    always_comb begin
        dm_hit = 1'b0;
        dm_id  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (avail[i]) begin
                dm_hit = 1'b1;
                dm_id  = IW'(i);
            end
        end
    end

    assign dm_gnt = dm_req && dm_hit;

    always_comb begin
        after_dm = avail;
        if (dm_gnt) after_dm[dm_id] = 1'b0;
    end

    always_comb begin
        pf_avail = 1'b0;
        pf_id    = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (after_dm[i]) begin
                pf_avail = 1'b1;
                pf_id    = IW'(i);
            end
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_trk
        always_ff @(posedge clk) begin
            if (rst)
                busy[g] <= 1'b0;
            else if ((dm_gnt && dm_id == IW'(g)) || (pf_take && pf_id == IW'(g)))
                busy[g] <= 1'b1;
            else if (rel_v && rel_id == IW'(g))
                busy[g] <= 1'b0;
        end
    end

    assign busy_cnt = CW'($countones(busy));

    a_r7_stall_only_full: assert property (@(posedge clk) disable iff (rst)
        (dm_req && !dm_gnt) |-> ((&busy) && !rel_v));

    a_r8_grant_held: assert property (@(posedge clk) disable iff (rst)
        dm_gnt |=> busy[$past(dm_id)]);

    a_r10_pf_distinct: assert property (@(posedge clk) disable iff (rst)
        (dm_gnt && pf_take) |-> (pf_id != dm_id));

endmodule

// File: rtl/pfq_admit.sv
module pfq_admit
    import pfq_pkg::*;
#(
    parameter int AW       = 32,
    parameter int PAGE_LSB = 12,
    parameter int DEPTH    = 32
) (
    input  logic [AW-1:0]              pf_addr,
    input  logic [AW-1:0]              trig,
    input  logic                       to_l2,
    input  logic [$clog2(DEPTH+1)-1:0] q_count,
    input  logic                       dq_push,
    input  logic                       trk_avail,
    output verdict_t                   verdict
);
    localparam int CW = $clog2(DEPTH + 1);

    logic same_page, room;

    assign same_page = pf_addr[AW-1:PAGE_LSB] == trig[AW-1:PAGE_LSB];
    assign room      = ({1'b0, q_count} + (CW+1)'(dq_push)) < (CW+1)'(DEPTH);

    // Reason priority: page, then room, then tracker
    always_comb begin
        verdict.ok  = 1'b0;
        verdict.why = WHY_NONE;
        if (!same_page)
            verdict.why = WHY_PAGE;
        else if (!room)
            verdict.why = WHY_FULL;
        else if (to_l2 && !trk_avail)
            verdict.why = WHY_TRK;
        else
            verdict.ok = 1'b1;
    end

endmodule

// File: rtl/pf_admit_tracker.sv
module pf_admit_tracker
    import pfq_pkg::*;
#(
    parameter int ADDR_W   = DEF_ADDR_W,
    parameter int PAGE_LSB = DEF_PAGE_LSB,
    parameter int RQ_DEPTH = DEF_RQ_DEPTH,
    parameter int TRK_NUM  = DEF_TRK_NUM
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          dq_valid,
    input  logic [ADDR_W-1:0]             dq_addr,
    output logic                          dq_ready,
    input  logic                          pf_valid,
    input  logic [ADDR_W-1:0]             pf_addr,
    input  logic [ADDR_W-1:0]             pf_trig,
    input  logic                          pf_to_l2,
    output logic                          pf_ack,
    output logic                          pf_nak,
    output logic [1:0]                    pf_why,
    output logic [$clog2(TRK_NUM)-1:0]    pf_trk,
    output logic                          rd_valid,
    input  logic                          rd_ready,
    output logic [ADDR_W-1:0]             rd_addr,
    output logic                          rd_is_pf,
    output logic                          rd_to_l2,
    output logic [$clog2(TRK_NUM)-1:0]    rd_trk,
    input  logic                          mq_valid,
    output logic                          mq_gnt,
    output logic                          mq_stall,
    output logic [$clog2(TRK_NUM)-1:0]    mq_trk,
    input  logic                          rel_valid,
    input  logic [$clog2(TRK_NUM)-1:0]    rel_trk,
    output logic [$clog2(RQ_DEPTH+1)-1:0] rq_count,
    output logic [$clog2(TRK_NUM+1)-1:0]  trk_count
);
    localparam int TW = $clog2(TRK_NUM);
    localparam int CW = $clog2(RQ_DEPTH + 1);
    localparam int EW = ADDR_W + 2 + TW;

    verdict_t      verdict;
    logic          dq_push, pf_fire, pf_take, pop;
    logic          pool_pf_avail;
    logic [TW-1:0] pool_pf_id;
    logic [EW-1:0] din_dm, din_pf, head;
    why_e          why_q;

    assign dq_ready = rq_count < CW'(RQ_DEPTH);
    assign dq_push  = dq_valid && dq_ready;
    assign rd_valid = rq_count != '0;
    assign pop      = rd_ready && rd_valid;
    assign pf_fire  = pf_valid && verdict.ok;
    assign pf_take  = pf_fire && pf_to_l2;
    assign mq_stall = mq_valid && !mq_gnt;

    // Entry layout: {to_l2, is_pf, tracker, address}
    assign din_dm = {1'b0, 1'b0, {TW{1'b0}}, dq_addr};
    assign din_pf = {pf_to_l2, 1'b1, (pf_to_l2 ? pool_pf_id : {TW{1'b0}}), pf_addr};
    assign {rd_to_l2, rd_is_pf, rd_trk, rd_addr} = head;

    pfq_admit #(
        .AW       (ADDR_W),
        .PAGE_LSB (PAGE_LSB),
        .DEPTH    (RQ_DEPTH)
    ) u_admit (
        .pf_addr   (pf_addr),
        .trig      (pf_trig),
        .to_l2     (pf_to_l2),
        .q_count   (rq_count),
        .dq_push   (dq_push),
        .trk_avail (pool_pf_avail),
        .verdict   (verdict)
    );

    pfq_pool #(
        .N (TRK_NUM)
    ) u_pool (
        .clk      (clk),
        .rst      (rst),
        .rel_v    (rel_valid),
        .rel_id   (rel_trk),
        .dm_req   (mq_valid),
        .pf_take  (pf_take),
        .dm_gnt   (mq_gnt),
        .dm_id    (mq_trk),
        .pf_avail (pool_pf_avail),
        .pf_id    (pool_pf_id),
        .busy_cnt (trk_count)
    );

    pfq_fifo #(
        .W     (EW),
        .DEPTH (RQ_DEPTH)
    ) u_fifo (
        .clk    (clk),
        .rst    (rst),
        .push_a (dq_push),
        .din_a  (din_dm),
        .push_b (pf_fire),
        .din_b  (din_pf),
        .pop    (pop),
        .head   (head),
        .count  (rq_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pf_ack <= 1'b0;
            pf_nak <= 1'b0;
            why_q  <= WHY_NONE;
            pf_trk <= '0;
        end else begin
            pf_ack <= pf_fire;
            pf_nak <= pf_valid && !verdict.ok;
            why_q  <= pf_valid ? verdict.why : WHY_NONE;
            pf_trk <= pool_pf_id;
        end
    end

    assign pf_why = why_q;

    a_r5_ack_nak_excl: assert property (@(posedge clk) disable iff (rst)
        !(pf_ack && pf_nak));

    a_r2_page_nak: assert property (@(posedge clk) disable iff (rst)
        (pf_valid && (pf_addr[ADDR_W-1:PAGE_LSB] != pf_trig[ADDR_W-1:PAGE_LSB]))
        |=> (pf_nak && pf_why == WHY_PAGE));

    a_r4_l3_no_trk: assert property (@(posedge clk) disable iff (rst)
        (pf_valid && !pf_to_l2) |=> !(pf_nak && pf_why == WHY_TRK));

    a_r11_full_blocks: assert property (@(posedge clk) disable iff (rst)
        (rq_count == CW'(RQ_DEPTH) && !rd_ready) |=> (rq_count == CW'(RQ_DEPTH)));

endmodule

// File: tb/test_pf_admit_tracker.sv
`timescale 1ns/1ps
module test_pf_admit_tracker;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dq_valid = 0;
    logic [31:0] dq_addr = '0;
    logic        dq_ready;
    logic        pf_valid = 0;
    logic [31:0] pf_addr = '0;
    logic [31:0] pf_trig = '0;
    logic        pf_to_l2 = 0;
    logic        pf_ack, pf_nak;
    logic [1:0]  pf_why;
    logic [3:0]  pf_trk;
    logic        rd_valid;
    logic        rd_ready = 0;
    logic [31:0] rd_addr;
    logic        rd_is_pf, rd_to_l2;
    logic [3:0]  rd_trk;
    logic        mq_valid = 0;
    logic        mq_gnt, mq_stall;
    logic [3:0]  mq_trk;
    logic        rel_valid = 0;
    logic [3:0]  rel_trk = '0;
    logic [5:0]  rq_count;
    logic [4:0]  trk_count;

    always #10 clk = ~clk;

    pf_admit_tracker i_pf_admit_tracker (
        .clk(clk), .rst(rst),
        .dq_valid(dq_valid), .dq_addr(dq_addr), .dq_ready(dq_ready),
        .pf_valid(pf_valid), .pf_addr(pf_addr), .pf_trig(pf_trig), .pf_to_l2(pf_to_l2),
        .pf_ack(pf_ack), .pf_nak(pf_nak), .pf_why(pf_why), .pf_trk(pf_trk),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
        .rd_is_pf(rd_is_pf), .rd_to_l2(rd_to_l2), .rd_trk(rd_trk),
        .mq_valid(mq_valid), .mq_gnt(mq_gnt), .mq_stall(mq_stall), .mq_trk(mq_trk),
        .rel_valid(rel_valid), .rel_trk(rel_trk),
        .rq_count(rq_count), .trk_count(trk_count)
    );

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // Reference state: entries packed as {to_l2, is_pf, trk[3:0], addr[31:0]}
    logic [37:0] mq_model[$];
    bit [15:0]   busy_m = '0;
    bit          e_ack = 0, e_nak = 0, e_l2 = 0;
    int          e_why = 0, e_trk = 0;

    task automatic chk(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic idle();
        dq_valid = 0; pf_valid = 0; mq_valid = 0; rel_valid = 0; rd_ready = 0;
        pf_to_l2 = 0;
    endtask

    // Compare all outputs against the model, then advance model and clock
    task automatic tick();
        int cnt, a, b, pfa;
        bit [15:0] av;
        bit g, dpush, page, room, ok;
        int why;
        logic [37:0] h;
        #2;
        cnt = mq_model.size();
        chk("R9 rq_count", rq_count, cnt);
        chk("R9 trk_count", trk_count, $countones(busy_m));
        chk("R11 dq_ready", dq_ready, cnt < 32);
        chk("R6 rd_valid", rd_valid, cnt > 0);
        if (cnt > 0) begin
            h = mq_model[0];
            chk("R6 rd_addr", rd_addr, h[31:0]);
            chk("R6 rd_trk", rd_trk, h[35:32]);
            chk("R6 rd_is_pf", rd_is_pf, h[36]);
            chk("R6 rd_to_l2", rd_to_l2, h[37]);
        end
        chk("R5 pf_ack", pf_ack, e_ack);
        chk("R5 pf_nak", pf_nak, e_nak);
        if (e_nak)
            chk(e_why == 1 ? "R2 pf_why" : (e_why == 2 ? "R3 pf_why" : "R4 pf_why"), pf_why, e_why);
        if (e_ack && e_l2) chk("R5 pf_trk", pf_trk, e_trk);

        av = ~busy_m;
        if (rel_valid) av[rel_trk] = 1'b1;
        a = -1; b = -1;
        for (int i = 0; i < 16; i++) begin
            if (av[i]) begin
                if (a < 0) a = i;
                else if (b < 0) b = i;
            end
        end
        g = mq_valid && (a >= 0);
        chk("R7 mq_gnt", mq_gnt, g);
        chk("R7 mq_stall", mq_stall, mq_valid && !g);
        if (g) chk("R7 mq_trk", mq_trk, a);
        pfa = g ? b : a;

        dpush = dq_valid && (cnt < 32);
        page  = pf_addr[31:12] != pf_trig[31:12];
        room  = (cnt + int'(dpush)) < 32;
        ok = 0; why = 0;
        if (page) why = 1;
        else if (!room) why = 2;
        else if (pf_to_l2 && pfa < 0) why = 3;
        else ok = 1;

        if (rd_ready && cnt > 0) void'(mq_model.pop_front());
        if (dpush) mq_model.push_back({1'b0, 1'b0, 4'd0, dq_addr});
        if (pf_valid && ok)
            mq_model.push_back({pf_to_l2, 1'b1, (pf_to_l2 ? 4'(pfa) : 4'd0), pf_addr});
        if (rel_valid) busy_m[rel_trk] = 1'b0;
        if (g) busy_m[a] = 1'b1;
        if (pf_valid && ok && pf_to_l2) busy_m[pfa] = 1'b1;
        e_ack = pf_valid && ok;
        e_nak = pf_valid && !ok;
        e_why = why;
        e_l2  = pf_to_l2;
        e_trk = pfa;

        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(20ns * 150000);
        if (!done) begin
            errors++;
            $display("FAIL R6 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: state right after reset
        #1;
        chk("R1 rd_valid", rd_valid, 0);
        chk("R1 rq_count", rq_count, 0);
        chk("R1 trk_count", trk_count, 0);
        chk("R1 pf_ack", pf_ack, 0);
        chk("R1 pf_nak", pf_nak, 0);
        @(negedge clk);
        tick();

        // R6: demand reads queue in order
        for (int i = 0; i < 3; i++) begin
            idle(); dq_valid = 1; dq_addr = 32'h1000 + 32'(i * 64); tick();
        end
        // R5: lower-level prefetch on same page; R2: page cross
        idle(); pf_valid = 1; pf_addr = 32'h5040; pf_trig = 32'h5000; tick();
        idle(); pf_valid = 1; pf_addr = 32'h6000; pf_trig = 32'h5FC0; tick();
        // R6: demand and prefetch written together
        idle(); dq_valid = 1; dq_addr = 32'h7000; pf_valid = 1; pf_addr = 32'h7080;
        pf_trig = 32'h7000; pf_to_l2 = 1; tick();
        idle(); rd_ready = 1; repeat (8) tick();

        // R3/R11: fill queue to 31 then contend for the last slot
        for (int i = 0; i < 31; i++) begin
            idle(); dq_valid = 1; dq_addr = 32'h20000 + 32'(i * 64); tick();
        end
        idle(); dq_valid = 1; dq_addr = 32'h30000; pf_valid = 1;
        pf_addr = 32'h9000; pf_trig = 32'h9040; tick();
        idle(); pf_valid = 1; pf_addr = 32'h9000; pf_trig = 32'h9040; tick();
        idle(); dq_valid = 1; dq_addr = 32'h31000; tick();
        idle(); tick();
        idle(); rd_ready = 1; repeat (34) tick();

        // Trackers: use all 16 (R7), then stall
        for (int i = 0; i < 16; i++) begin
            idle(); mq_valid = 1; tick();
        end
        idle(); mq_valid = 1; tick();
        // R4: this-level prefetch refused, lower-level prefetch accepted
        idle(); pf_valid = 1; pf_addr = 32'hA000; pf_trig = 32'hA100; pf_to_l2 = 1; tick();
        idle(); pf_valid = 1; pf_addr = 32'hA000; pf_trig = 32'hA100; pf_to_l2 = 0; tick();
        // R8: release and reallocate in one cycle
        idle(); rel_valid = 1; rel_trk = 4'd5; mq_valid = 1; tick();
        // R8: duplicate release ignored
        idle(); rel_valid = 1; rel_trk = 4'd3; tick();
        idle(); rel_valid = 1; rel_trk = 4'd3; tick();
        // R10: one free register, demand wins
        idle(); mq_valid = 1; pf_valid = 1; pf_addr = 32'hB000; pf_trig = 32'hB000;
        pf_to_l2 = 1; tick();
        idle(); tick();
        for (int i = 0; i < 16; i++) begin
            idle(); rel_valid = 1; rel_trk = 4'(i); rd_ready = 1; tick();
        end
        idle(); pf_valid = 1; pf_addr = 32'hC000; pf_trig = 32'hC000; pf_to_l2 = 1; tick();

        // Mixed traffic against the model
        for (int n = 0; n < 3000; n++) begin
            idle();
            rd_ready  = ($urandom_range(0, 99) < 45);
            dq_valid  = ($urandom_range(0, 99) < 40);
            dq_addr   = $urandom & 32'hFFFF_FFC0;
            pf_valid  = ($urandom_range(0, 99) < 50);
            pf_trig   = $urandom & 32'hFFFF_FFC0;
            pf_addr   = {pf_trig[31:12], 12'($urandom_range(0, 63) * 64)};
            if ($urandom_range(0, 99) < 20) pf_addr = pf_addr ^ 32'h0000_1000;
            pf_to_l2  = $urandom_range(0, 1);
            mq_valid  = ($urandom_range(0, 99) < 30);
            rel_valid = ($urandom_range(0, 99) < 40);
            rel_trk   = 4'($urandom_range(0, 15));
            tick();
        end

        idle(); tick();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule